// File: doc/BRIEF.md
# Program Flash Table Access Controller

This block lets a processor core move single bytes between a 16-bit-wide program flash and its 8-bit register bus. A 22-bit byte pointer and an 8-bit transfer latch sit behind a small register window. A table read copies the addressed flash byte into the latch, at any byte address. A table write places the latch into a 64-byte staging buffer, at the slot named by the pointer's six low bits.

A program operation copies the whole staging buffer into one aligned 64-byte flash block. An erase operation fills that block with FFh. The pointer bits above the low six pick the block. Either operation starts only when software sets the start bit right after a two-byte key sequence, with write-enable and the flash-select bit already set. While the operation runs, the block holds instruction fetch stalled. An internal timer ends the operation. The flash array is behavioural and sized by a parameter. Pointer bits above the array size alias.

Registers, chosen by `reg_sel`: 0 pointer bits 7:0, 1 pointer bits 15:8, 2 pointer bits 21:16 (in data bits 5:0), 3 latch, 4 control/status, 5 key. Control/status bits: 0 start (reads 1 while busy), 1 write-enable, 2 erase-select, 3 error, 4 flash-select, 5 done.

Top module: `tblx_ctrl`

## Requirements
- R1: A `tbl_rd` pulse loads the latch with flash byte `ptr` (modulo the array size), where even byte addresses hold the low half of a 16-bit word and odd addresses hold the high half. An erased byte reads FFh.
- R2: A `tbl_wr` pulse stores the latch into staging slot `ptr[5:0]`. A program operation writes all 64 slots into the block `ptr[ADDR_W-1:6]`, whatever the pointer's low bits. Bytes outside that block keep their values.
- R3: With control bit 2 set, a started operation sets all 64 bytes of the selected block to FFh and leaves other blocks unchanged.
- R4: A write of control bit 0 = 1 starts an operation only in the cycle right after the key register received 55h and then AAh. Any other register access or table pulse between the two keys, or between AAh and the start write, cancels the sequence. An idle cycle after AAh also cancels it.
- R5: Write-enable (control bit 1) is 0 after power-up. A start attempt with write-enable clear has no effect.
- R6: Software cannot clear control bit 0: while an operation runs it reads 1 even after a write of 0. It returns to 0 when the timer finishes.
- R7: `fetch_stall` is 0 after reset. It rises in the cycle after an accepted start and stays high for exactly PROG_CYCLES cycles.
- R8: The key register holds nothing and always reads 00h.
- R9: Done (control bit 5, also `done_irq`) sets when an operation completes. It stays set until software writes that bit as 0. Writing it as 1 leaves it unchanged.
- R10: A warm reset (`rst_n` low) during an operation abandons it. The flash block stays unchanged and error (control bit 3) is set. Error survives warm resets and is cleared by power-on reset or by writing the bit as 0. Warm reset clears write-enable, erase-select, flash-select and the staging buffer.
- R11: After every completed program operation, all 64 staging slots read back as FFh, so a following program with no table writes leaves the block all FFh.
- R12: A start attempt with flash-select (control bit 4) clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything including flash |
| rst_n | input | 1 | Warm reset, active low, synchronous; aborts an operation |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (counts as an access for the key sequence) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tbl_rd | input | 1 | Table read pulse |
| tbl_wr | input | 1 | Table write pulse |
| fetch_stall | output | 1 | Instruction fetch stall while an operation runs |
| done_irq | output | 1 | Completion flag |

## Verification
The bench targets the key sequence's edges: an access slipped between the two keys, a pointer write between them, an idle cycle after AAh, and keys in the wrong order. A design that tracked the keys loosely would start an operation in one of these cases and commit the staged byte. It launches a program with the pointer in mid-block, so a design that used the pointer's low bits for the block address would write the wrong block. It checks the stall length, the staging buffer refilled with FFh after a commit, erase leaving the neighbour block intact, and a warm reset mid-operation. A design that committed early, kept stale staging data, or lost the error flag on warm reset would fail these checks.

// File: rtl/tblx_pkg.sv
package tblx_pkg;

  typedef enum logic [2:0] {
    SEL_PTR_LO  = 3'd0,
    SEL_PTR_MID = 3'd1,
    SEL_PTR_UP  = 3'd2,
    SEL_LATCH   = 3'd3,
    SEL_CTRL    = 3'd4,
    SEL_KEY     = 3'd5
  } reg_sel_e;

  // control/status bit positions
  localparam int CB_GO     = 0;
  localparam int CB_WREN   = 1;
  localparam int CB_ERASE  = 2;
  localparam int CB_ERR    = 3;
  localparam int CB_MEMSEL = 4;
  localparam int CB_DONE   = 5;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  // byte lane of a flash word: odd byte address is the upper half
  function automatic logic [7:0] pick_byte(input logic [15:0] word, input logic hi);
    return hi ? word[15:8] : word[7:0];
  endfunction

  function automatic logic [15:0] pack_word(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/tblx_unlock.sv
module tblx_unlock
  import tblx_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       any_acc,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       armed
);

  logic first_seen;
  logic hit_first, hit_second;

  assign hit_first  = key_wr && (key_data == KEY_FIRST);
  assign hit_second = key_wr && (key_data == KEY_SECOND) && first_seen;

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      first_seen <= 1'b0;
      armed      <= 1'b0;
    end else begin
      // armed lives for exactly the cycle after the second key
      armed <= hit_second;
      if (hit_first)    first_seen <= 1'b1;
      else if (any_acc) first_seen <= 1'b0;
    end
  end

endmodule

// File: rtl/tblx_holdbuf.sv
module tblx_holdbuf #(
  parameter  int BLK_BYTES = 64,
  localparam int IDX_W     = $clog2(BLK_BYTES)
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             wdata,
  input  logic                   refill,
  output logic [BLK_BYTES*8-1:0] flat
);

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!por_n || !rst_n || refill)
        flat[g*8 +: 8] <= 8'hFF;
      else if (wr_en && (idx == IDX_W'(g)))
        flat[g*8 +: 8] <= wdata;
    end
  end

endmodule

// File: rtl/tblx_flash.sv
module tblx_flash
  import tblx_pkg::*;
#(
  parameter  int FLASH_BYTES = 1024,
  parameter  int BLK_BYTES   = 64,
  parameter  int PROG_CYCLES = 16,
  localparam int ADDR_W      = $clog2(FLASH_BYTES),
  localparam int IDX_W       = $clog2(BLK_BYTES),
  localparam int BLK_W       = ADDR_W - IDX_W
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   erase,
  input  logic [BLK_W-1:0]       blk,
  input  logic [BLK_BYTES*8-1:0] buf_flat,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_byte,
  output logic                   busy,
  output logic                   done
);

  localparam int WORDS     = FLASH_BYTES / 2;
  localparam int BLK_WORDS = BLK_BYTES / 2;
  localparam int WIDX_W    = IDX_W - 1;
  localparam int CNT_W     = $clog2(PROG_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic [15:0]      mem [WORDS];
  logic [CNT_W-1:0] cnt;
  logic             busy_q, erase_q;
  logic [BLK_W-1:0] blk_q;

  assign busy    = busy_q;
  assign done    = busy_q && (cnt == LAST) && rst_n;
  assign rd_byte = pick_byte(mem[rd_addr[ADDR_W-1:1]], rd_addr[0]);

  // programming timer
  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      busy_q  <= 1'b0;
      cnt     <= '0;
      erase_q <= 1'b0;
      blk_q   <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      cnt     <= '0;
      erase_q <= erase;
      blk_q   <= blk;
    end else if (busy_q) begin
      if (cnt == LAST) busy_q <= 1'b0;
      else             cnt    <= cnt + 1'b1;
    end
  end

  // array: erased at power-on, block updated only when the timer ends
  always_ff @(posedge clk) begin
    if (!por_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= 16'hFFFF;
    end else if (done) begin
      for (int w = 0; w < BLK_WORDS; w++)
        mem[{blk_q, WIDX_W'(w)}] <= erase_q ? 16'hFFFF
                                   : pack_word(buf_flat[16*w +: 8], buf_flat[16*w+8 +: 8]);
    end
  end

endmodule

// File: rtl/tblx_ctrl.sv
module tblx_ctrl
  import tblx_pkg::*;
#(
  parameter int FLASH_BYTES = 1024,
  parameter int BLK_BYTES   = 64,
  parameter int PROG_CYCLES = 16,
  parameter int PTR_W       = 22
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [2:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tbl_rd,
  input  logic       tbl_wr,
  output logic       fetch_stall,
  output logic       done_irq
);

  localparam int ADDR_W = $clog2(FLASH_BYTES);
  localparam int IDX_W  = $clog2(BLK_BYTES);
  localparam int BLK_W  = ADDR_W - IDX_W;
  localparam int UP_W   = PTR_W - 16;

  logic [PTR_W-1:0]       ptr_q;
  logic [7:0]             latch_q;
  logic                   wren_q, erase_q, memsel_q, err_q, done_q, op_erase_q;
  logic                   busy, op_done, armed, go_fire;
  logic                   any_acc, key_wr, wr_ctrl;
  logic [7:0]             flash_byte;
  logic [BLK_BYTES*8-1:0] buf_flat;

  assign any_acc = reg_we || reg_re || tbl_rd || tbl_wr;
  assign key_wr  = reg_we && (reg_sel == SEL_KEY);
  assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
  assign go_fire = wr_ctrl && reg_wdata[CB_GO] && armed && wren_q && memsel_q && !busy;

  assign fetch_stall = busy;
  assign done_irq    = done_q;

  tblx_unlock u_unlock (
    .clk      (clk),
    .por_n    (por_n),
    .rst_n    (rst_n),
    .any_acc  (any_acc),
    .key_wr   (key_wr),
    .key_data (reg_wdata),
    .armed    (armed)
  );

  tblx_holdbuf #(.BLK_BYTES(BLK_BYTES)) u_hbuf (
    .clk    (clk),
    .por_n  (por_n),
    .rst_n  (rst_n),
    .wr_en  (tbl_wr && !busy),
    .idx    (ptr_q[IDX_W-1:0]),
    .wdata  (latch_q),
    .refill (op_done && !op_erase_q),
    .flat   (buf_flat)
  );

  tblx_flash #(
    .FLASH_BYTES (FLASH_BYTES),
    .BLK_BYTES   (BLK_BYTES),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_flash (
    .clk      (clk),
    .por_n    (por_n),
    .rst_n    (rst_n),
    .start    (go_fire),
    .erase    (erase_q),
    .blk      (ptr_q[ADDR_W-1:IDX_W]),
    .buf_flat (buf_flat),
    .rd_addr  (ptr_q[ADDR_W-1:0]),
    .rd_byte  (flash_byte),
    .busy     (busy),
    .done     (op_done)
  );

  // pointer and latch
  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      ptr_q   <= '0;
      latch_q <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_PTR_LO)  ptr_q[7:0]       <= reg_wdata;
      if (reg_we && reg_sel == SEL_PTR_MID) ptr_q[15:8]      <= reg_wdata;
      if (reg_we && reg_sel == SEL_PTR_UP)  ptr_q[PTR_W-1:16] <= reg_wdata[UP_W-1:0];
      if (reg_we && reg_sel == SEL_LATCH)   latch_q <= reg_wdata;
      else if (tbl_rd && !busy)             latch_q <= flash_byte;
    end
  end

  // control/status
  always_ff @(posedge clk) begin
    if (!por_n) begin
      wren_q <= 1'b0; erase_q <= 1'b0; memsel_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; op_erase_q <= 1'b0;
    end else if (!rst_n) begin
      wren_q <= 1'b0; erase_q <= 1'b0; memsel_q <= 1'b0;
      done_q <= 1'b0; op_erase_q <= 1'b0;
      if (busy) err_q <= 1'b1;
    end else begin
      if (wr_ctrl) begin
        wren_q   <= reg_wdata[CB_WREN];
        erase_q  <= reg_wdata[CB_ERASE];
        memsel_q <= reg_wdata[CB_MEMSEL];
        if (!reg_wdata[CB_ERR]) err_q <= 1'b0;
      end
      if (go_fire) op_erase_q <= erase_q;
      if (op_done) done_q <= 1'b1;
      else if (wr_ctrl && !reg_wdata[CB_DONE]) done_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_sel)
      SEL_PTR_LO:  reg_rdata = ptr_q[7:0];
      SEL_PTR_MID: reg_rdata = ptr_q[15:8];
      SEL_PTR_UP:  reg_rdata = 8'(ptr_q[PTR_W-1:16]);
      SEL_LATCH:   reg_rdata = latch_q;
      SEL_CTRL: begin
        reg_rdata[CB_GO]     = busy;
        reg_rdata[CB_WREN]   = wren_q;
        reg_rdata[CB_ERASE]  = erase_q;
        reg_rdata[CB_ERR]    = err_q;
        reg_rdata[CB_MEMSEL] = memsel_q;
        reg_rdata[CB_DONE]   = done_q;
      end
      default:     reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/tblx_sva.sv
module tblx_sva #(
  parameter int BLK_BYTES = 64
) (
  input logic                   clk,
  input logic                   por_n,
  input logic                   rst_n,
  input logic                   fetch_stall,
  input logic                   done_irq,
  input logic                   armed,
  input logic                   wren_q,
  input logic                   memsel_q,
  input logic                   err_q,
  input logic                   op_done,
  input logic                   op_erase_q,
  input logic [BLK_BYTES*8-1:0] buf_flat
);

  AST_START_AFTER_KEYS: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(fetch_stall) |-> $past(armed)); // R4

  AST_START_NEEDS_WREN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(fetch_stall) |-> $past(wren_q)); // R5

  AST_START_NEEDS_MEMSEL: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(fetch_stall) |-> $past(memsel_q)); // R12

  AST_STALL_HELD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (fetch_stall && !op_done) |=> fetch_stall); // R6

  AST_DONE_FLAGGED: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    op_done |=> (done_irq && !fetch_stall)); // R9

  AST_BUF_REFILLED: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (op_done && !op_erase_q) |=> (buf_flat == '1)); // R11

  AST_ABORT_FLAGS_ERR: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && fetch_stall) |=> err_q); // R10

endmodule

bind tblx_ctrl tblx_sva #(.BLK_BYTES(BLK_BYTES)) u_sva (
  .clk         (clk),
  .por_n       (por_n),
  .rst_n       (rst_n),
  .fetch_stall (fetch_stall),
  .done_irq    (done_irq),
  .armed       (armed),
  .wren_q      (wren_q),
  .memsel_q    (memsel_q),
  .err_q       (err_q),
  .op_done     (op_done),
  .op_erase_q  (op_erase_q),
  .buf_flat    (buf_flat)
);

// File: tb/tblx_ctrl_tb.sv
`timescale 1ns/1ps
module tblx_ctrl_tb;

  localparam int FB = 1024;
  localparam int BB = 64;
  localparam int PC = 16;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0;
  logic       reg_we = 1'b0, reg_re = 1'b0, tbl_rd = 1'b0, tbl_wr = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       fetch_stall, done_irq;

  always #2.5 clk = ~clk;

  tblx_ctrl #(.FLASH_BYTES(FB), .BLK_BYTES(BB), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .reg_we(reg_we), .reg_re(reg_re), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tbl_rd(tbl_rd), .tbl_wr(tbl_wr),
    .fetch_stall(fetch_stall), .done_irq(done_irq)
  );

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t q[$];
  logic obs = 1'b0;
  int   n_cmp = 0, n_bad = 0;
  bit   ended = 0;

  logic [7:0] mdl [FB];
  logic [7:0] hbuf [BB];

  // monitor: pops one expected item per observed register read
  always @(negedge clk) begin
    if (obs) begin
      exp_t e;
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: got %02h expected none", reg_rdata);
      end else begin
        e = q.pop_front();
        if (reg_rdata !== e.exp) begin
          n_bad++;
          $display("FAIL %s: got %02h expected %02h", e.tag, reg_rdata, e.exp);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wreg(input logic [2:0] s, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [7:0] e, input string tag);
    reg_re = 1'b1; reg_sel = s;
    q.push_back('{e, tag});
    obs = 1'b1;
    tick();
    reg_re = 1'b0; obs = 1'b0;
  endtask

  task automatic setptr(input logic [21:0] a);
    wreg(3'd0, a[7:0]);
    wreg(3'd1, a[15:8]);
    wreg(3'd2, {2'b00, a[21:16]});
  endtask

  task automatic tread(input logic [21:0] a, input string tag);
    setptr(a);
    tbl_rd = 1'b1; tick(); tbl_rd = 1'b0;
    rd(3'd3, mdl[int'(a) % FB], tag);
  endtask

  task automatic twrite(input logic [21:0] a, input logic [7:0] d);
    setptr(a);
    wreg(3'd3, d);
    tbl_wr = 1'b1; tick(); tbl_wr = 1'b0;
    hbuf[int'(a) % BB] = d;
  endtask

  task automatic launch(input logic [21:0] a, input logic [7:0] ctl);
    setptr(a);
    wreg(3'd5, 8'h55);
    wreg(3'd5, 8'hAA);
    wreg(3'd4, ctl | 8'h01);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (fetch_stall && n < 1000) begin tick(); n++; end
  endtask

  task automatic commit_model(input logic [21:0] a, input bit erase);
    int base;
    base = ((int'(a) % FB) / BB) * BB;
    for (int i = 0; i < BB; i++) mdl[base + i] = erase ? 8'hFF : hbuf[i];
    if (!erase) for (int i = 0; i < BB; i++) hbuf[i] = 8'hFF;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!ended) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < FB; i++) mdl[i] = 8'hFF;
    for (int i = 0; i < BB; i++) hbuf[i] = 8'hFF;
    repeat (3) @(posedge clk);
    #1; por_n = 1'b1; rst_n = 1'b1;
    tick();

    // reset state
    chk(fetch_stall == 1'b0, "R7 stall after reset", fetch_stall, 0);
    rd(3'd4, 8'h00, "R5 ctrl after power-up");
    rd(3'd3, 8'h00, "R1 latch after reset");
    rd(3'd5, 8'h00, "R8 key reads zero");
    wreg(3'd5, 8'h55);
    rd(3'd5, 8'h00, "R8 key after write");
    tread(22'h000005, "R1 erased byte");

    // fill block 3 and program it with the pointer mid-block
    for (int i = 0; i < BB; i++) twrite(22'h0000C0 + 22'(i), 8'(i * 7 + 3));
    wreg(3'd4, 8'h12);
    launch(22'h0000E5, 8'h12);
    chk(fetch_stall == 1'b1, "R7 stall after start", fetch_stall, 1);
    wreg(3'd4, 8'h12);
    rd(3'd4, 8'h13, "R6 start bit not clearable");
    wait_done(n);
    chk(n == PC - 2, "R7 stall length (partial)", n, PC - 2);
    rd(3'd4, 8'h32, "R9 done set, R6 start cleared");
    chk(done_irq == 1'b1, "R9 done_irq", done_irq, 1);
    commit_model(22'h0000E5, 0);
    for (int i = 0; i < BB; i++) tread(22'h0000C0 + 22'(i), "R2 programmed byte");
    tread(22'h0000BF, "R2 byte below block");
    tread(22'h000100, "R2 byte above block");
    tread(22'h2000C1, "R1 upper pointer bits alias");

    // program with no table writes: staging buffer must be FFh
    wreg(3'd4, 8'h12);
    launch(22'h000080, 8'h12);
    chk(fetch_stall == 1'b1, "R7 stall rises", fetch_stall, 1);
    wait_done(n);
    chk(n == PC, "R7 stall length", n, PC);
    commit_model(22'h000080, 0);
    tread(22'h000080, "R11 refilled buffer");
    tread(22'h0000BF, "R11 refilled buffer");

    // done flag persistence
    repeat (20) tick();
    rd(3'd4, 8'h32, "R9 done held");
    wreg(3'd4, 8'h32);
    rd(3'd4, 8'h32, "R9 write one keeps done");
    wreg(3'd4, 8'h12);
    rd(3'd4, 8'h12, "R9 write zero clears done");

    // partial program of block 4
    twrite(22'h000105, 8'h5A);
    twrite(22'h00013E, 8'hC3);
    launch(22'h000100, 8'h12);
    wait_done(n);
    commit_model(22'h000100, 0);
    tread(22'h000105, "R2 partial block");
    tread(22'h00013E, "R2 partial block");
    tread(22'h000106, "R11 stale slot");

    // erase block 3
    wreg(3'd4, 8'h16);
    launch(22'h0000C7, 8'h16);
    wait_done(n);
    chk(n == PC, "R3 erase duration", n, PC);
    commit_model(22'h0000C7, 1);
    tread(22'h0000C0, "R3 erased");
    tread(22'h0000C1, "R3 erased");
    tread(22'h0000FF, "R3 erased");
    tread(22'h000105, "R3 neighbour kept");

    // key sequence violations
    wreg(3'd4, 8'h12);
    twrite(22'h000181, 8'h77);
    wreg(3'd5, 8'h55); wreg(3'd5, 8'hAA);
    rd(3'd5, 8'h00, "R8 key read in sequence");
    wreg(3'd4, 8'h13);
    chk(fetch_stall == 1'b0, "R4 access after second key", fetch_stall, 0);
    rd(3'd4, 8'h12, "R4 start bit stays clear");
    wreg(3'd5, 8'h55); wreg(3'd0, 8'h81); wreg(3'd5, 8'hAA); wreg(3'd4, 8'h13);
    chk(fetch_stall == 1'b0, "R4 write between keys", fetch_stall, 0);
    wreg(3'd5, 8'h55); wreg(3'd5, 8'hAA); tick(); wreg(3'd4, 8'h13);
    chk(fetch_stall == 1'b0, "R4 idle cycle before start", fetch_stall, 0);
    wreg(3'd5, 8'hAA); wreg(3'd5, 8'h55); wreg(3'd4, 8'h13);
    chk(fetch_stall == 1'b0, "R4 keys reversed", fetch_stall, 0);
    wreg(3'd4, 8'h10);
    launch(22'h000181, 8'h10);
    chk(fetch_stall == 1'b0, "R5 write-enable clear", fetch_stall, 0);
    wreg(3'd4, 8'h02);
    launch(22'h000181, 8'h02);
    chk(fetch_stall == 1'b0, "R12 flash-select clear", fetch_stall, 0);
    tread(22'h000181, "R4 no commit happened");

    // warm reset during an operation
    wreg(3'd4, 8'h12);
    twrite(22'h000181, 8'h77);
    launch(22'h000180, 8'h12);
    chk(fetch_stall == 1'b1, "R4 proper sequence starts", fetch_stall, 1);
    tick(); tick();
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    for (int i = 0; i < BB; i++) hbuf[i] = 8'hFF;
    chk(fetch_stall == 1'b0, "R10 stall dropped", fetch_stall, 0);
    rd(3'd4, 8'h08, "R10 error set");
    tread(22'h000181, "R10 block unchanged");
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    rd(3'd4, 8'h08, "R10 error survives warm reset");
    wreg(3'd4, 8'h00);
    rd(3'd4, 8'h00, "R10 error cleared");

    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule